// File: doc/BRIEF.md
# Analog Input Card Host Register Interface

This block sits between a host register bus and the conversion engine of a multi-channel analog input card. It decodes host reads and writes by register address. It serves a fixed identification byte, and it treats a write to that same address as a soft reset. It also presents a status register and a packed 16-bit result word. A host starts a conversion by writing a channel number to the channel register. The card accepts that number only while it is idle. When it accepts the number, it latches the channel, marks itself busy and sends a one-cycle start pulse to the engine.

When the engine reports completion, the block captures four things: the pacing flag, the active-low common-mode overrange flag, the sign and the raw 12-bit magnitude. It then clears busy. Read data is registered, so it appears one clock after the read strobe and is marked by a valid pulse.

Top module: `adc_host_regs`

## Requirements
- R1: After reset, `busy`, `conv_start`, `prom_clr` and `chan_sel` are 0, and a read of the result register (address 0) returns 0x0000.
- R2: A read of address 1 returns 0x0012 (identification value 18 in bits 7..0, upper bits 0) on `host_rdata` one cycle after `host_rd`, with `host_rvalid` high in that cycle.
- R3: A write of any data to address 1 clears `busy` on the next cycle and pulses `prom_clr` high for one cycle.
- R4: A write to address 2 while not busy does three things on the next cycle: it latches `host_wdata` into `chan_sel`, it sets `busy`, and it pulses `conv_start` for one cycle.
- R5: A write to address 2 while busy has no effect: `chan_sel` keeps its value, `conv_start` stays low and `busy` stays high.
- R6: `conv_done` while busy captures `conv_late`, `conv_ovr_n`, `conv_neg` and `conv_mag`, and clears `busy` on the next cycle.
- R7: The result word at address 0 has this layout: bit 15 is busy (1 = busy), bit 14 is the pacing-late flag, bit 13 is the overrange flag (0 = overrange occurred), bit 12 is the sign (1 = negative), and bits 11..0 are the raw magnitude.
- R8: The status register at address 2'b11 (address 3) reads with bit 6 equal to the inverse of busy and all other bits 0.
- R9: Reads of addresses 4 to 7 return 0x0000. Writes to addresses 0, 3 and 4 to 7 change no state.
- R10: A soft-reset write in the same cycle as `conv_done` leaves `busy` at 0, and the result register is not updated.
- R11: `conv_done` while not busy is ignored; the result register keeps its value.
- R12: A channel write in the same cycle as `conv_done` while busy is rejected: `busy` clears, `chan_sel` is unchanged and no `conv_start` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W (3) | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | CHAN_W (3) | Write data (channel number for address 2) |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| conv_done | input | 1 | Engine result ready |
| conv_late | input | 1 | Reading was not properly paced |
| conv_ovr_n | input | 1 | Common-mode overrange, active low |
| conv_neg | input | 1 | Sign of reading, 1 = negative |
| conv_mag | input | 12 | Raw magnitude |
| conv_start | output | 1 | One-cycle conversion start pulse |
| chan_sel | output | CHAN_W (3) | Latched channel number |
| busy | output | 1 | Conversion in progress |
| prom_clr | output | 1 | One-cycle pulse that clears the sequence counter |

## Verification
The engine's completion can arrive in the same cycle as two kinds of host write. One is a soft-reset write to address 1. The other is a channel write to address 2 while the card is busy. The bench sets up both collisions by raising `conv_done` with a distinctive magnitude in the same cycle as the write strobe. For the soft-reset collision, it judges that busy is low and that a later read of the result word still shows the earlier capture. For the channel-write collision, it judges that busy clears, no start pulse appears, the channel is unchanged and the new result is in the result word.

// File: rtl/adc_host_regs_pkg.sv
// Package: register addresses, fixed values and the packed result word layout
// shared by the host register interface modules.
package adc_host_regs_pkg;
    localparam int          REG_RESULT    = 0;
    localparam int          REG_IDENT     = 1;
    localparam int          REG_CHAN      = 2;
    localparam int          REG_STATUS    = 3;
    localparam logic [7:0]  IDENT_VALUE   = 8'd18;
    localparam int          STAT_IDLE_BIT = 6;
    localparam int          MAG_W         = 12;
    localparam int          WORD_W        = 16;

    // Result word, MSB first: busy, pacing late, overrange (active low), sign, magnitude.
    typedef struct packed {
        logic             busy;
        logic             late;
        logic             ovr_n;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } result_word_t;
endpackage

// File: rtl/adc_busy_ctrl.sv
// Module: adc_busy_ctrl
// Tracks the busy state and latches the channel number of an accepted request.
// Assumes one host write per cycle, so a soft reset and a channel write never coincide.
// Soft reset has priority over completion, and a request is judged against busy
// as it stands at the start of the cycle.
module adc_busy_ctrl #(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              soft_rst,
    input  logic              conv_done,
    output logic              busy,
    output logic              conv_start,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              capture
);
    logic accept;

    // Accept a request only when idle and not in a soft-reset cycle.
    always_comb begin
        accept  = req_wr && !busy && !soft_rst;
        capture = conv_done && busy && !soft_rst;
    end

    // Busy flag, start pulse and channel latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            chan_sel   <= '0;
        end else begin
            conv_start <= accept;
            if (soft_rst) begin
                busy <= 1'b0;
            end else if (capture) begin
                busy <= 1'b0;
            end else if (accept) begin
                busy     <= 1'b1;
                chan_sel <= req_chan;
            end
        end
    end

    // R3: soft reset always leaves the card idle
    p_soft_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy);
    // R4: busy only rises together with a start pulse
    p_rise_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start);
    // R5: a busy card never issues a start pulse next cycle
    p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !conv_start);
    // R5: channel latch moves only with a start pulse
    p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(chan_sel));
    // R6: completion while busy frees the card
    p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);
endmodule

// File: rtl/adc_result_hold.sv
// Module: adc_result_hold
// Holds the fields of the last accepted conversion result.
// Assumes the capture strobe is already qualified by busy and soft reset.
module adc_result_hold
    import adc_host_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             in_late,
    input  logic             in_ovr_n,
    input  logic             in_neg,
    input  logic [MAG_W-1:0] in_mag,
    output logic             late,
    output logic             ovr_n,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    // Register the engine outputs on an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late  <= 1'b0;
            ovr_n <= 1'b0;
            neg   <= 1'b0;
            mag   <= '0;
        end else if (capture) begin
            late  <= in_late;
            ovr_n <= in_ovr_n;
            neg   <= in_neg;
            mag   <= in_mag;
        end
    end

    // R11: without a capture strobe the held result does not move
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(mag) && $stable(neg) && $stable(ovr_n) && $stable(late)));
endmodule

// File: rtl/adc_reg_decode.sv
// Module: adc_reg_decode
// Decodes host strobes by address and drives the registered read port.
// Assumes read data reflects the state before any same-cycle write.
module adc_reg_decode
    import adc_host_regs_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              busy,
    input  logic              late,
    input  logic              ovr_n,
    input  logic              neg,
    input  logic [MAG_W-1:0]  mag,
    output logic              req_wr,
    output logic              soft_rst,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              prom_clr
);
    localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(REG_RESULT);
    localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(REG_IDENT);
    localparam logic [ADDR_W-1:0] A_CHAN   = ADDR_W'(REG_CHAN);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

    result_word_t       word;
    logic [WORD_W-1:0]  status;
    logic [WORD_W-1:0]  rmux;

    // Write strobe decode.
    always_comb begin
        req_wr   = wr && (addr == A_CHAN);
        soft_rst = wr && (addr == A_IDENT);
    end

    // Read source selection; undefined addresses give zero.
    always_comb begin
        word                 = '{busy: busy, late: late, ovr_n: ovr_n, neg: neg, mag: mag};
        status               = '0;
        status[STAT_IDLE_BIT] = ~busy;
        case (addr)
            A_RESULT: rmux = word;
            A_IDENT:  rmux = {{(WORD_W-8){1'b0}}, IDENT_VALUE};
            A_STATUS: rmux = status;
            default:  rmux = '0;
        endcase
    end

    // Registered read data, valid flag and sequence counter clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rvalid   <= 1'b0;
            prom_clr <= 1'b0;
        end else begin
            rvalid   <= rd;
            prom_clr <= soft_rst;
            if (rd) rdata <= rmux;
        end
    end

    // R2: identification register reads back 18
    p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_IDENT) |=> (rdata == 16'h0012 && rvalid));
    // R8: status idle bit mirrors the inverse of busy
    p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_STATUS) |=> (rdata[STAT_IDLE_BIT] == !$past(busy)
            && $countones(rdata) <= 1));
    // R9: undefined addresses read zero
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr > A_STATUS) |=> (rdata == '0));
    // R3: soft reset write yields the clear pulse
    p_prom_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_IDENT) |=> prom_clr);
endmodule

// File: rtl/adc_host_regs.sv
// Module: adc_host_regs (top)
// Host register interface of an analog input card: identification/soft reset,
// channel request with busy interlock, status, and the packed result word.
// Assumes single-cycle host strobes and a conversion engine that raises
// conv_done for one cycle with its result fields valid in that cycle.
module adc_host_regs
    import adc_host_regs_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [CHAN_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              conv_done,
    input  logic              conv_late,
    input  logic              conv_ovr_n,
    input  logic              conv_neg,
    input  logic [MAG_W-1:0]  conv_mag,
    output logic              conv_start,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              busy,
    output logic              prom_clr
);
    logic             req_wr;
    logic             soft_rst;
    logic             capture;
    logic             r_late;
    logic             r_ovr_n;
    logic             r_neg;
    logic [MAG_W-1:0] r_mag;

    adc_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .wr       (host_wr),
        .rd       (host_rd),
        .busy     (busy),
        .late     (r_late),
        .ovr_n    (r_ovr_n),
        .neg      (r_neg),
        .mag      (r_mag),
        .req_wr   (req_wr),
        .soft_rst (soft_rst),
        .rdata    (host_rdata),
        .rvalid   (host_rvalid),
        .prom_clr (prom_clr)
    );

    adc_busy_ctrl #(.CHAN_W(CHAN_W)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (req_wr),
        .req_chan   (host_wdata),
        .soft_rst   (soft_rst),
        .conv_done  (conv_done),
        .busy       (busy),
        .conv_start (conv_start),
        .chan_sel   (chan_sel),
        .capture    (capture)
    );

    adc_result_hold u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .in_late  (conv_late),
        .in_ovr_n (conv_ovr_n),
        .in_neg   (conv_neg),
        .in_mag   (conv_mag),
        .late     (r_late),
        .ovr_n    (r_ovr_n),
        .neg      (r_neg),
        .mag      (r_mag)
    );

    // R12: a channel write meeting completion never starts a conversion
    p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && host_wr && host_addr == ADDR_W'(REG_CHAN)) |=> (!conv_start && !busy));
    // R10: soft reset meeting completion leaves the card idle
    p_soft_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && host_wr && host_addr == ADDR_W'(REG_IDENT)) |=> !busy);
endmodule

// File: tb/adc_host_regs_tb.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and compares.
module adc_host_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        conv_done = 1'b0;
    logic        conv_late = 1'b0;
    logic        conv_ovr_n = 1'b0;
    logic        conv_neg = 1'b0;
    logic [11:0] conv_mag = '0;
    logic        conv_start;
    logic [2:0]  chan_sel;
    logic        busy;
    logic        prom_clr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .conv_done(conv_done), .conv_late(conv_late),
        .conv_ovr_n(conv_ovr_n), .conv_neg(conv_neg), .conv_mag(conv_mag),
        .conv_start(conv_start), .chan_sel(chan_sel), .busy(busy), .prom_clr(prom_clr)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic release_bus();
        host_wr = 1'b0; host_rd = 1'b0; conv_done = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        tick();
        release_bus();
    endtask

    task automatic do_write(input logic [2:0] a, input logic [2:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
    endtask

    task automatic set_result(input logic l, input logic o, input logic s, input logic [11:0] m);
        conv_done = 1'b1; conv_late = l; conv_ovr_n = o; conv_neg = s; conv_mag = m;
    endtask

    // Monitor: compare each valid read word against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard: unexpected read 0x%04h expected none", host_rdata);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        check("R1 busy", 16'(busy), 16'h0);
        check("R1 chan", 16'(chan_sel), 16'h0);
        check("R1 start", 16'(conv_start), 16'h0);
        check("R1 prom_clr", 16'(prom_clr), 16'h0);
        do_read(3'd0, 16'h0000, "R1 result after reset");
        do_read(3'd1, 16'h0012, "R2 ident");
        do_read(3'd3, 16'h0040, "R8 status idle");

        // R4 accept channel 5
        do_write(3'd2, 3'd5); tick(); release_bus();
        check("R4 busy set", 16'(busy), 16'h1);
        check("R4 start pulse", 16'(conv_start), 16'h1);
        check("R4 chan latched", 16'(chan_sel), 16'h5);
        tick();
        check("R4 start one cycle", 16'(conv_start), 16'h0);
        do_read(3'd3, 16'h0000, "R8 status busy");
        do_read(3'd0, 16'h8000, "R7 busy bit in word");

        // R5 request while busy
        do_write(3'd2, 3'd3); tick(); release_bus();
        check("R5 chan kept", 16'(chan_sel), 16'h5);
        check("R5 no start", 16'(conv_start), 16'h0);
        check("R5 still busy", 16'(busy), 16'h1);

        // R6 completion
        set_result(1'b1, 1'b1, 1'b1, 12'hABC); tick(); release_bus();
        check("R6 busy cleared", 16'(busy), 16'h0);
        do_read(3'd0, 16'h7ABC, "R6 R7 result fields");

        // R11 completion while idle
        set_result(1'b0, 1'b0, 1'b0, 12'h123); tick(); release_bus();
        do_read(3'd0, 16'h7ABC, "R11 idle done ignored");

        // R9 undefined reads and ignored writes
        do_read(3'd5, 16'h0000, "R9 undefined read 5");
        do_read(3'd7, 16'h0000, "R9 undefined read 7");
        do_write(3'd6, 3'd7); tick(); release_bus();
        do_write(3'd0, 3'd7); tick(); release_bus();
        do_write(3'd3, 3'd7); tick(); release_bus();
        check("R9 busy untouched", 16'(busy), 16'h0);
        check("R9 chan untouched", 16'(chan_sel), 16'h5);
        check("R9 no prom_clr", 16'(prom_clr), 16'h0);
        do_read(3'd0, 16'h7ABC, "R9 result untouched");

        // R3 soft reset while busy
        do_write(3'd2, 3'd2); tick(); release_bus();
        check("R3 pre busy", 16'(busy), 16'h1);
        do_write(3'd1, 3'd0); tick(); release_bus();
        check("R3 busy cleared", 16'(busy), 16'h0);
        check("R3 prom_clr pulse", 16'(prom_clr), 16'h1);
        tick();
        check("R3 prom_clr one cycle", 16'(prom_clr), 16'h0);

        // R10 soft reset meets completion
        do_write(3'd2, 3'd4); tick(); release_bus();
        do_write(3'd1, 3'd0); set_result(1'b0, 1'b0, 1'b0, 12'h555); tick(); release_bus();
        check("R10 busy low", 16'(busy), 16'h0);
        do_read(3'd0, 16'h7ABC, "R10 result not updated");

        // R12 channel write meets completion
        do_write(3'd2, 3'd1); tick(); release_bus();
        check("R12 pre chan", 16'(chan_sel), 16'h1);
        do_write(3'd2, 3'd6); set_result(1'b0, 1'b1, 1'b0, 12'h0F0); tick(); release_bus();
        check("R12 busy cleared", 16'(busy), 16'h0);
        check("R12 no start", 16'(conv_start), 16'h0);
        check("R12 chan unchanged", 16'(chan_sel), 16'h1);
        do_read(3'd0, 16'h20F0, "R12 R7 new result");

        // R4 acceptance resumes afterwards
        do_write(3'd2, 3'd7); tick(); release_bus();
        check("R4 chan 7", 16'(chan_sel), 16'h7);
        tick(); tick();
        check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule